// File: doc/BRIEF.md
# Active priority tracker

This block records which interrupt priorities are currently being serviced on a physical CPU interface. Three interrupt groups are tracked (group 0, secure group 1, non-secure group 1). Each group has its own active-priority bit vector. Acknowledging an interrupt sets the bit that stands for its group priority. Ending an interrupt clears the highest active priority of its group. From the union of the three vectors the block derives the running priority that the rest of the interface uses to decide preemption.

The number of implemented priority bits is a synthesis parameter, from 4 to 8. From it follow:
- the number of preemption bits, which is the same value except that 8 priority bits give 7;
- the number of 32-bit active-priority words per group;
- the bit index an acknowledged priority maps to;
- the scaling of the running priority;
- the floors of the per-group binary-point registers;
- the bits the priority mask register keeps.

The surrounding interface drives one-cycle operation strobes: activate, drop, binary-point write, mask write and active-word write. It reads back the active words through a combinational read port.

Top module: `active_prio_tracker`

## Requirements
- R1: An activate with a valid group sets, one clock later, bit k = (prio & gmask) >> (8 − PRE) of that group's vector, and the read port shows it in word k/32 at bit k%32. PRE is PRI_BITS, or 7 when PRI_BITS is 8. gmask is (0xFF << (e+1)) & 0xFF, where e is the group's binary point, minus one for group code 2.
- R2: An activate whose ID lies in 1020..1023 changes no active bit.
- R3: A drop clears only the lowest-numbered set bit of the named group. Other groups are unchanged, and a drop on an empty group has no effect.
- R4: run_prio is (k << (8 − PRE)), where k is the lowest set bit index in the OR of the three vectors. It is 0xFF when no bit is set.
- R5: A binary-point write stores the written value, raised to 7 − PRE if it is lower. For group code 2 the floor is 8 − PRE.
- R6: A mask write stores the data ANDed with (0xFF << (8 − PRI_BITS)) & 0xFF.
- R7: In reset the mask is 0, every binary point is at its floor, every active bit is clear and run_prio is 0xFF.
- R8: Each group holds NW = 1 << max(PRE − 5, 0) words. A word write replaces one word. Word indices NW and above read as zero and ignore writes.
- R9: When operations coincide in one cycle, the drop is applied first, then the activate, then a word write, which overrides the written word.
- R10: Group codes are 0 = group 0, 1 = secure group 1 and 2 = non-secure group 1. Code 3 makes activate, drop, binary-point write and word write do nothing, and makes the read port return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate strobe |
| act_grp | input | 2 | Group of the acknowledged interrupt |
| act_prio | input | 8 | Priority of the acknowledged interrupt |
| act_id | input | ID_W | Interrupt ID |
| drop_valid | input | 1 | Priority-drop strobe |
| drop_grp | input | 2 | Group to drop |
| bpr_wr | input | 1 | Binary-point write strobe |
| bpr_grp | input | 2 | Group of the binary point |
| bpr_wdata | input | 3 | Binary-point value |
| pmr_wr | input | 1 | Mask write strobe |
| pmr_wdata | input | 8 | Mask value |
| apr_wr | input | 1 | Active-word write strobe |
| apr_grp | input | 2 | Group of the written word |
| apr_idx | input | 2 | Index of the written word |
| apr_wdata | input | 32 | Word data |
| rd_grp | input | 2 | Read port group |
| rd_idx | input | 2 | Read port word index |
| rd_data | output | 32 | Selected active word |
| run_prio | output | 8 | Running priority |
| prio_mask | output | 8 | Priority mask register |
| bpr_g0 | output | 3 | Group 0 binary point |
| bpr_g1s | output | 3 | Secure group 1 binary point |
| bpr_g1ns | output | 3 | Non-secure group 1 binary point |

## Verification
Some properties hold on every cycle:
- the binary points never fall below their floors;
- the mask never holds unimplemented bits;
- the running priority always lies on the preemption grid;
- an ID in 1020..1023 freezes the active bits;
- a lone drop removes exactly one bit;
- a valid activate leaves the block non-idle.

The bench's scenarios are needed for the rest. These cover which bit index a given priority and binary point select, that a drop picks the lowest bit rather than just any bit, and the ordering when drop, activate and word write coincide. They also cover the zero readback of unimplemented words and the exact running-priority value. These are checked against a behavioural model on every clock.

// File: rtl/active_prio_tracker.sv
module active_prio_tracker #(
  parameter int PRI_BITS = 6,
  parameter int ID_W     = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_valid,
  input  logic [1:0]      act_grp,
  input  logic [7:0]      act_prio,
  input  logic [ID_W-1:0] act_id,
  input  logic            drop_valid,
  input  logic [1:0]      drop_grp,
  input  logic            bpr_wr,
  input  logic [1:0]      bpr_grp,
  input  logic [2:0]      bpr_wdata,
  input  logic            pmr_wr,
  input  logic [7:0]      pmr_wdata,
  input  logic            apr_wr,
  input  logic [1:0]      apr_grp,
  input  logic [1:0]      apr_idx,
  input  logic [31:0]     apr_wdata,
  input  logic [1:0]      rd_grp,
  input  logic [1:0]      rd_idx,
  output logic [31:0]     rd_data,
  output logic [7:0]      run_prio,
  output logic [7:0]      prio_mask,
  output logic [2:0]      bpr_g0,
  output logic [2:0]      bpr_g1s,
  output logic [2:0]      bpr_g1ns
);
  localparam int PRE = (PRI_BITS == 8) ? 7 : PRI_BITS;
  localparam int NW  = (PRE > 5) ? (1 << (PRE - 5)) : 1;
  localparam int TOT = NW * 32;
  localparam int SH  = 8 - PRE;
  localparam logic [2:0] BMIN    = 3'(7 - PRE);
  localparam logic [2:0] BMIN_NS = 3'(8 - PRE);
  localparam logic [7:0] PMASK   = 8'((32'hff << (8 - PRI_BITS)) & 32'hff);
  localparam logic [7:0] GRIDM   = 8'((1 << SH) - 1);

  logic [TOT-1:0] apr_q [3];
  logic [2:0]     bpr_q [3];
  logic [7:0]     pmr_q;

  function automatic logic [7:0] gmask(input logic [1:0] g, input logic [2:0] b);
    int e;
    e = (g == 2'd2) ? int'(b) - 1 : int'(b);
    return 8'((32'hff << (e + 1)) & 32'hff);
  endfunction

  function automatic logic [TOT-1:0] pick(input logic [1:0] g);
    case (g)
      2'd0:    return apr_q[0];
      2'd1:    return apr_q[1];
      2'd2:    return apr_q[2];
      default: return '0;
    endcase
  endfunction

  logic [2:0] act_bpr;
  assign act_bpr = (act_grp == 2'd0) ? bpr_q[0] :
                   (act_grp == 2'd1) ? bpr_q[1] : bpr_q[2];

  logic           is_special, act_hit;
  logic [7:0]     act_k;
  logic [TOT-1:0] act_bit;
  assign is_special = (act_id >= ID_W'(1020)) && (act_id <= ID_W'(1023));
  assign act_hit    = act_valid && (act_grp != 2'd3) && !is_special;
  assign act_k      = (act_prio & gmask(act_grp, act_bpr)) >> SH;
  assign act_bit    = TOT'(1) << act_k;

  for (genvar g = 0; g < 3; g++) begin : g_grp
    logic [TOT-1:0] nxt;
    always_comb begin
      nxt = apr_q[g];
      if (drop_valid && drop_grp == 2'(g)) nxt = nxt & ~(apr_q[g] & (~apr_q[g] + TOT'(1)));
      if (act_hit && act_grp == 2'(g)) nxt = nxt | act_bit;
      for (int w = 0; w < NW; w++)
        if (apr_wr && apr_grp == 2'(g) && apr_idx == 2'(w)) nxt[w*32 +: 32] = apr_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        apr_q[g] <= '0;
        bpr_q[g] <= (g == 2) ? BMIN_NS : BMIN;
      end else begin
        apr_q[g] <= nxt;
        if (bpr_wr && bpr_grp == 2'(g)) begin
          if (bpr_wdata < ((g == 2) ? BMIN_NS : BMIN)) bpr_q[g] <= (g == 2) ? BMIN_NS : BMIN;
          else bpr_q[g] <= bpr_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pmr_q <= '0;
    else if (pmr_wr) pmr_q <= pmr_wdata & PMASK;
  end

  logic [TOT-1:0] all_or;
  int             low_k;
  assign all_or = apr_q[0] | apr_q[1] | apr_q[2];
  always_comb begin
    low_k = 0;
    for (int i = TOT - 1; i >= 0; i--) if (all_or[i]) low_k = i;
  end
  assign run_prio = (|all_or) ? 8'(low_k << SH) : 8'hff;

  logic [TOT-1:0] rsel;
  assign rsel = pick(rd_grp);
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NW; w++) if (rd_idx == 2'(w)) rd_data = rsel[w*32 +: 32];
  end

  assign prio_mask = pmr_q;
  assign bpr_g0    = bpr_q[0];
  assign bpr_g1s   = bpr_q[1];
  assign bpr_g1ns  = bpr_q[2];

  logic [3*TOT-1:0] all_apr;
  assign all_apr = {apr_q[2], apr_q[1], apr_q[0]};

  AST_BPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    bpr_g0 >= BMIN && bpr_g1s >= BMIN && bpr_g1ns >= BMIN_NS); // R5
  AST_PMR_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_mask & ~PMASK) == 8'h00); // R6
  AST_RPR_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    run_prio != 8'hff |-> (run_prio & GRIDM) == 8'h00); // R4
  AST_SPECIAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_id >= ID_W'(1020) && act_id <= ID_W'(1023) && !drop_valid && !apr_wr
    |=> $stable(all_apr)); // R2
  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && drop_grp != 2'd3 && (|pick(drop_grp)) && !act_valid && !apr_wr
    |=> $countones(all_apr) == $past($countones(all_apr)) - 1); // R3
  AST_ACT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_grp != 2'd3 && act_id < ID_W'(1020) && !apr_wr
    |=> run_prio != 8'hff); // R1
endmodule

// File: tb/active_prio_tracker_tb.sv
module active_prio_tracker_tb;
  localparam int PRI  = 6;
  localparam int PRE  = (PRI == 8) ? 7 : PRI;
  localparam int NW   = (PRE > 5) ? (1 << (PRE - 5)) : 1;
  localparam int TOT  = NW * 32;
  localparam int SH   = 8 - PRE;
  localparam int BMIN = 7 - PRE;
  localparam int PMSK = (255 << (8 - PRI)) & 255;

  logic clk = 0, rst_n = 0;
  logic act_valid = 0, drop_valid = 0, bpr_wr = 0, pmr_wr = 0, apr_wr = 0;
  logic [1:0] act_grp = 0, drop_grp = 0, bpr_grp = 0, apr_grp = 0, apr_idx = 0, rd_grp = 0, rd_idx = 0;
  logic [7:0] act_prio = 0, pmr_wdata = 0;
  logic [23:0] act_id = 0;
  logic [2:0] bpr_wdata = 0;
  logic [31:0] apr_wdata = 0;
  logic [31:0] rd_data;
  logic [7:0] run_prio, prio_mask;
  logic [2:0] bpr_g0, bpr_g1s, bpr_g1ns;

  active_prio_tracker #(.PRI_BITS(PRI), .ID_W(24)) u_dut (
    .clk, .rst_n, .act_valid, .act_grp, .act_prio, .act_id, .drop_valid, .drop_grp,
    .bpr_wr, .bpr_grp, .bpr_wdata, .pmr_wr, .pmr_wdata, .apr_wr, .apr_grp, .apr_idx,
    .apr_wdata, .rd_grp, .rd_idx, .rd_data, .run_prio, .prio_mask, .bpr_g0, .bpr_g1s, .bpr_g1ns);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, rptr = 0;
  bit done = 0;
  bit m_apr [0:2][0:127];
  int m_bpr [0:2];
  int m_pmr;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_rpr();
    for (int i = 0; i < TOT; i++)
      if (m_apr[0][i] || m_apr[1][i] || m_apr[2][i]) return i << SH;
    return 255;
  endfunction

  function automatic int m_word(int g, int w);
    int v = 0;
    if (g == 3 || w >= NW) return 0;
    for (int b = 0; b < 32; b++) if (m_apr[g][w*32+b]) v |= (1 << b);
    return v;
  endfunction

  function automatic int m_gmask(int g);
    int e = (g == 2) ? m_bpr[g] - 1 : m_bpr[g];
    return (255 << (e + 1)) & 255;
  endfunction

  task automatic check_all();
    chk("R4 running priority", int'(run_prio), m_rpr());
    chk("R6 mask register", int'(prio_mask), m_pmr);
    chk("R5 binary point g0", int'(bpr_g0), m_bpr[0]);
    chk("R5 binary point g1s", int'(bpr_g1s), m_bpr[1]);
    chk("R5 binary point g1ns", int'(bpr_g1ns), m_bpr[2]);
    chk("R1/R8/R10 active word", int'(rd_data), m_word(int'(rd_grp), int'(rd_idx)));
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
    act_valid = 0; drop_valid = 0; bpr_wr = 0; pmr_wr = 0; apr_wr = 0;
    rptr = (rptr + 1) % 16;
    rd_grp = 2'(rptr / 4); rd_idx = 2'(rptr % 4);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // one cycle of operations; model follows R9 order: drop, activate, word write
  task automatic op(bit da, int ag, int ap, int aid, bit dd, int dg, bit dw, int wg, int wi, int wd);
    tick();
    act_valid = da; act_grp = 2'(ag); act_prio = 8'(ap); act_id = 24'(aid);
    drop_valid = dd; drop_grp = 2'(dg);
    apr_wr = dw; apr_grp = 2'(wg); apr_idx = 2'(wi); apr_wdata = 32'(wd);
    if (dd && dg != 3) begin
      for (int i = 0; i < TOT; i++) if (m_apr[dg][i]) begin m_apr[dg][i] = 0; break; end
    end
    if (da && ag != 3 && !(aid >= 1020 && aid <= 1023))
      m_apr[ag][(ap & m_gmask(ag)) >> SH] = 1;
    if (dw && wg != 3 && wi < NW)
      for (int b = 0; b < 32; b++) m_apr[wg][wi*32+b] = (wd >> b) & 1;
  endtask

  task automatic bprw(int g, int v);
    tick();
    bpr_wr = 1; bpr_grp = 2'(g); bpr_wdata = 3'(v);
    if (g != 3) begin
      int mn = (g == 2) ? BMIN + 1 : BMIN;
      m_bpr[g] = (v < mn) ? mn : v;
    end
  endtask

  task automatic pmrw(int v);
    tick();
    pmr_wr = 1; pmr_wdata = 8'(v);
    m_pmr = v & PMSK;
  endtask

  task automatic activate(int g, int p, int id);
    op(1, g, p, id, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drop(int g);
    op(0, 0, 0, 0, 1, g, 0, 0, 0, 0);
  endtask

  task automatic wword(int g, int w, int d);
    op(0, 0, 0, 0, 0, 0, 1, g, w, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 3; g++) for (int i = 0; i < 128; i++) m_apr[g][i] = 0;
    m_bpr[0] = BMIN; m_bpr[1] = BMIN; m_bpr[2] = BMIN + 1; m_pmr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset values
    chk("R7 reset running priority", int'(run_prio), 255);
    chk("R7 reset mask", int'(prio_mask), 0);
    chk("R7 reset bpr g0", int'(bpr_g0), BMIN);
    chk("R7 reset bpr g1ns", int'(bpr_g1ns), BMIN + 1);
    rst_n = 1;
    idle(16);

    // R6 mask write drops low bits
    pmrw(8'hff); pmrw(8'h57); idle(2);
    // R5 clamp below floor, keep larger values, code 3 ignored (R10)
    bprw(0, 0); bprw(2, 0); bprw(1, 5); bprw(3, 6); idle(2);
    bprw(1, 0); idle(1);

    // R1 activate in each group, R4 running priority follows lowest index
    activate(2, 8'h80, 40); idle(3);
    activate(0, 8'h40, 41); idle(3);
    activate(1, 8'hc7, 42); idle(16);
    // R2 special IDs ignored, R10 group code 3 ignored
    activate(0, 8'h04, 1020); activate(1, 8'h00, 1023); activate(3, 8'h00, 7); idle(3);
    activate(1, 8'h08, 1024); idle(3);
    // R3 drop clears lowest bit of one group only
    drop(1); idle(3); drop(1); idle(3); drop(1); idle(3);
    drop(3); idle(3);
    // group priority masking with a coarser binary point
    bprw(0, 4); activate(0, 8'h3f, 50); idle(16);
    bprw(2, 3); activate(2, 8'h2b, 51); idle(16);
    bprw(0, 1); bprw(2, 2);
    // R8 word writes, unimplemented words ignored
    wword(1, 1, 32'h0000_0100); wword(1, 2, 32'hffff_ffff); wword(2, 3, 32'h1); idle(16);
    wword(0, 0, 0); wword(2, 0, 0); wword(2, 1, 0); idle(16);
    // R9 coincident drop + activate + word write
    activate(0, 8'h10, 60); activate(0, 8'h28, 61); idle(3);
    op(1, 0, 8'h10, 62, 1, 0, 0, 0, 0, 0); idle(16);
    op(1, 2, 8'h20, 63, 1, 0, 1, 2, 0, 32'h0000_0001); idle(16);
    op(1, 1, 8'h44, 64, 0, 0, 1, 1, 0, 0); idle(16);

    for (int n = 0; n < 600; n++) begin
      int k = $urandom % 8;
      int ids [4] = '{17, 1020 + int'($urandom % 4), 3000, 1019};
      case (k)
        0, 1: activate(int'($urandom % 4), int'($urandom % 256), ids[$urandom % 4]);
        2, 3: drop(int'($urandom % 4));
        4: bprw(int'($urandom % 4), int'($urandom % 8));
        5: pmrw(int'($urandom % 256));
        6: wword(int'($urandom % 4), int'($urandom % 4), ($urandom % 3 == 0) ? int'($urandom) : 0);
        default: op(1, int'($urandom % 4), int'($urandom % 256), 9, 1, int'($urandom % 4),
                    $urandom % 2 == 1, int'($urandom % 4), int'($urandom % 4), int'($urandom));
      endcase
    end
    idle(20);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule